// File: doc/BRIEF.md
# Inquire Cycle Snoop Responder

This block answers inquire cycles that system logic raises against a processor with separate instruction and data caches. Each accepted strobe presents one address to both caches at once. The block reports whether any cache holds the line and whether the data-cache copy is dirty. It then moves the line to its new state. The instruction cache keeps one valid bit per line. The data cache keeps a four-state coherence code per line.

A single invalidate input selects the outcome. When it is low, a data line that hits is downgraded to shared, and an instruction line keeps its valid bit. When it is high, every hit line is dropped. A dirty data line is always pushed out over a valid/ready writeback port before its state changes. The producer holds `wb_valid`, `wb_addr` and `wb_data` steady until it sees `wb_ready` high at a clock edge. The sink may hold `wb_ready` low for as long as it needs. The line's state is committed on the edge where the transfer completes.

The tag and state arrays are direct-mapped and sit inside the block. An install port writes lines into them on behalf of the refill path outside the block.

Top module: `inquire_snoop`

## Requirements
- R1: Each accepted strobe looks up both caches. On the next cycle, `snp_hit` is 1 if either cache holds a valid line with a matching tag, and the result holds until the next accepted strobe.
- R2: An instruction-cache hit with `snp_inv`=0 leaves the line valid.
- R3: An instruction-cache hit with `snp_inv`=1 clears the line's valid bit.
- R4: A data-cache hit on an exclusive or shared line with `snp_inv`=0 leaves the line shared, raises no `snp_hitm` and starts no writeback.
- R5: A data-cache hit on a modified line raises `snp_hitm`. It writes the line back with address {tag,index,zero offset} and the stored data. With `snp_inv`=0 the line then becomes shared.
- R6: A data-cache hit with `snp_inv`=1 leaves the line invalid. If the line was modified, it is written back first.
- R7: `snp_inv` is sampled on the strobe cycle, and later changes to it during the operation have no effect.
- R8: `snp_busy` is high from the cycle after a dirty-hit strobe until the writeback completes. Strobes presented while busy are ignored and change neither results nor state.
- R9: `wb_valid`, `wb_addr` and `wb_data` hold steady while `wb_ready` is low. The line state is committed on the handshake edge, and `snp_busy` falls on the next cycle.
- R10: A strobe that misses in both caches, including a miss on a matching index with a different tag, drives `snp_hit` and `snp_hitm` low and changes no line.
- R11: `fill_en` writes a line only when the block is not busy and no strobe is present in that cycle. `fill_dcache`=1 selects the data cache. `fill_state` codes a data line, and any nonzero code marks an instruction line valid.
- R12: `snp_dstate` reports the data line's state before the snoop (0 invalid, 1 shared, 2 exclusive, 3 modified), and 0 when the data cache misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Inquire strobe |
| snp_addr | input | ADDR_W | Inquire address |
| snp_inv | input | 1 | Invalidate request, sampled with the strobe |
| snp_busy | output | 1 | Writeback in progress; strobes ignored |
| snp_hit | output | 1 | Line present in either cache |
| snp_hitm | output | 1 | Data line was modified |
| snp_dstate | output | 2 | Data line state before the snoop |
| wb_valid | output | 1 | Writeback offer |
| wb_ready | input | 1 | Writeback accept |
| wb_addr | output | ADDR_W | Line-aligned writeback address |
| wb_data | output | LINE_W | Writeback line data |
| fill_en | input | 1 | Install a line |
| fill_dcache | input | 1 | 1 data cache, 0 instruction cache |
| fill_addr | input | ADDR_W | Install address |
| fill_state | input | 2 | Install state code |
| fill_data | input | LINE_W | Install data (data cache) |

## Verification
The snoop results and `snp_busy` are registered on the strobe edge, so they are due one cycle after the strobe. The writeback offer appears in that same cycle. The state change is due on the edge that completes the handshake, and `snp_busy` is low one cycle later. A later snoop reveals that state through `snp_hit` and `snp_dstate`. A behavioural model in the bench advances on each rising edge from the same stable inputs. The outputs are compared against it on every falling edge, so each result is checked in the exact cycle it is due. Stalled and patterned `wb_ready` stretch the writeback so that ignored strobes and installs land inside the busy window.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2,
    LS_MOD = 2'd3
  } line_st_e;
endpackage

// File: rtl/snoop_itag.sv
module snoop_itag #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic [TAG_W-1:0] ins_tag,
  input  logic             ins_vld,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  logic [SETS-1:0]  vld_q;
  logic [TAG_W-1:0] tag_q [SETS];

  assign rd_vld = vld_q[rd_idx];
  assign rd_tag = tag_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (ins_en) vld_q[ins_idx] <= ins_vld;
      if (clr_en) vld_q[clr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) tag_q[ins_idx] <= ins_tag;
  end

  // install and snoop clear never share a cycle
  p_ins_clr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_en && clr_en));
endmodule

// File: rtl/snoop_dtag.sv
module snoop_dtag
  import snoop_pkg::*;
#(
  parameter int SETS   = 16,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 23,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output line_st_e          rd_st,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data,
  input  logic              ins_en,
  input  logic [IDX_W-1:0]  ins_idx,
  input  logic [TAG_W-1:0]  ins_tag,
  input  line_st_e          ins_st,
  input  logic [LINE_W-1:0] ins_data,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  upd_idx,
  input  line_st_e          upd_st
);
  line_st_e          st_q   [SETS];
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  assign rd_st   = st_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];
  assign rd_data = data_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= LS_INV;
    end else begin
      if (ins_en) st_q[ins_idx] <= ins_st;
      if (upd_en) st_q[upd_idx] <= upd_st;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) begin
      tag_q[ins_idx]  <= ins_tag;
      data_q[ins_idx] <= ins_data;
    end
  end

  // a snoop only ever downgrades a line
  p_upd_downgrade_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> (upd_st == LS_INV || upd_st == LS_SHR));
  p_ins_upd_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ins_en && upd_en));
endmodule

// File: rtl/inquire_snoop.sv
module inquire_snoop
  import snoop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 64,
  parameter int OFF_W  = 5,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_inv,
  output logic              snp_busy,
  output logic              snp_hit,
  output logic              snp_hitm,
  output logic [1:0]        snp_dstate,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [LINE_W-1:0] wb_data,
  input  logic              fill_en,
  input  logic              fill_dcache,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_state,
  input  logic [LINE_W-1:0] fill_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

  typedef enum logic {S_IDLE, S_WB} fsm_e;

  fsm_e             st_q;
  logic [IDX_W-1:0] q_idx;
  logic [TAG_W-1:0] q_tag;
  logic             q_inv;
  logic             hit_q, hitm_q;
  line_st_e         dst_q;

  logic [IDX_W-1:0] s_idx, f_idx, rd_idx;
  logic [TAG_W-1:0] s_tag, f_tag;
  assign s_idx = snp_addr[OFF_W +: IDX_W];
  assign s_tag = snp_addr[ADDR_W-1 -: TAG_W];
  assign f_idx = fill_addr[OFF_W +: IDX_W];
  assign f_tag = fill_addr[ADDR_W-1 -: TAG_W];

  logic accept, in_wb, wb_fire, ins_ok;
  assign in_wb   = (st_q == S_WB);
  assign accept  = snp_valid && !in_wb;
  assign wb_fire = in_wb && wb_ready;
  assign ins_ok  = fill_en && !in_wb && !snp_valid;
  assign rd_idx  = in_wb ? q_idx : s_idx;

  logic              i_vld;
  logic [TAG_W-1:0]  i_tag, d_tag;
  line_st_e          d_st;
  logic [LINE_W-1:0] d_data;

  logic i_hit, d_hit, d_dirty;
  assign i_hit   = i_vld && (i_tag == s_tag);
  assign d_hit   = (d_st != LS_INV) && (d_tag == s_tag);
  assign d_dirty = d_hit && (d_st == LS_MOD);

  logic     d_upd_en;
  line_st_e d_upd_st;
  assign d_upd_en = (accept && d_hit && !d_dirty) || wb_fire;
  assign d_upd_st = (in_wb ? q_inv : snp_inv) ? LS_INV : LS_SHR;

  snoop_itag #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_itag (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_vld  (i_vld),
    .rd_tag  (i_tag),
    .ins_en  (ins_ok && !fill_dcache),
    .ins_idx (f_idx),
    .ins_tag (f_tag),
    .ins_vld (fill_state != 2'd0),
    .clr_en  (accept && i_hit && snp_inv),
    .clr_idx (s_idx)
  );

  snoop_dtag #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_dtag (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_st    (d_st),
    .rd_tag   (d_tag),
    .rd_data  (d_data),
    .ins_en   (ins_ok && fill_dcache),
    .ins_idx  (f_idx),
    .ins_tag  (f_tag),
    .ins_st   (line_st_e'(fill_state)),
    .ins_data (fill_data),
    .upd_en   (d_upd_en),
    .upd_idx  (in_wb ? q_idx : s_idx),
    .upd_st   (d_upd_st)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      hit_q  <= 1'b0;
      hitm_q <= 1'b0;
      dst_q  <= LS_INV;
      q_idx  <= '0;
      q_tag  <= '0;
      q_inv  <= 1'b0;
    end else if (accept) begin
      hit_q  <= i_hit || d_hit;
      hitm_q <= d_dirty;
      dst_q  <= d_hit ? d_st : LS_INV;
      q_idx  <= s_idx;
      q_tag  <= s_tag;
      q_inv  <= snp_inv;
      if (d_dirty) st_q <= S_WB;
    end else if (wb_fire) begin
      st_q <= S_IDLE;
    end
  end

  assign snp_busy   = in_wb;
  assign snp_hit    = hit_q;
  assign snp_hitm   = hitm_q;
  assign snp_dstate = dst_q;
  assign wb_valid   = in_wb;
  assign wb_addr    = {q_tag, q_idx, {OFF_W{1'b0}}};
  assign wb_data    = d_data;

  p_wb_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
  p_wb_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> !snp_busy);
  p_busy_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snp_busy) |-> (snp_hitm && snp_hit));
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_busy |=> ($stable(snp_hit) && $stable(snp_hitm) && $stable(snp_dstate)));
  p_miss_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !i_hit && !d_hit) |=> (!snp_hit && !snp_hitm && !snp_busy));
endmodule

// File: tb/inquire_snoop_bench.sv
`timescale 1ns/1ps
module inquire_snoop_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snp_valid = 1'b0;
  logic [31:0] snp_addr = '0;
  logic        snp_inv = 1'b0;
  logic        snp_busy, snp_hit, snp_hitm;
  logic [1:0]  snp_dstate;
  logic        wb_valid;
  logic        wb_ready = 1'b1;
  logic [31:0] wb_addr;
  logic [63:0] wb_data;
  logic        fill_en = 1'b0;
  logic        fill_dcache = 1'b0;
  logic [31:0] fill_addr = '0;
  logic [1:0]  fill_state = '0;
  logic [63:0] fill_data = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rdy_mode = 0;   // 0 always ready, 1 never, 2 every third cycle
  bit done = 0;

  always #2 clk = ~clk;

  inquire_snoop u_inquire_snoop (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_inv(snp_inv), .snp_busy(snp_busy), .snp_hit(snp_hit), .snp_hitm(snp_hitm),
    .snp_dstate(snp_dstate), .wb_valid(wb_valid), .wb_ready(wb_ready),
    .wb_addr(wb_addr), .wb_data(wb_data), .fill_en(fill_en), .fill_dcache(fill_dcache),
    .fill_addr(fill_addr), .fill_state(fill_state), .fill_data(fill_data)
  );

  // behavioural reference
  bit          iv [16];
  int          itg[16];
  int          ds [16];
  int          dtg[16];
  logic [63:0] dd [16];
  bit m_busy, m_hit, m_hitm, m_inv;
  int m_dst, m_idx, m_tag;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin iv[i] = 0; ds[i] = 0; end
      m_busy = 0; m_hit = 0; m_hitm = 0; m_dst = 0;
    end else if (m_busy) begin
      if (wb_ready) begin ds[m_idx] = m_inv ? 0 : 1; m_busy = 0; end
    end else if (snp_valid) begin
      int ix, tg; bit ih, dh;
      ix = snp_addr[8:5]; tg = snp_addr[31:9];
      ih = iv[ix] && itg[ix] == tg;
      dh = ds[ix] != 0 && dtg[ix] == tg;
      m_hit = ih || dh;
      m_hitm = dh && ds[ix] == 3;
      m_dst = dh ? ds[ix] : 0;
      if (ih && snp_inv) iv[ix] = 0;
      if (dh) begin
        if (ds[ix] == 3) begin
          m_busy = 1; m_idx = ix; m_tag = tg; m_inv = snp_inv;
        end else ds[ix] = snp_inv ? 0 : 1;
      end
    end else if (fill_en) begin
      int ix; ix = fill_addr[8:5];
      if (fill_dcache) begin
        ds[ix] = fill_state; dtg[ix] = fill_addr[31:9]; dd[ix] = fill_data;
      end else begin
        iv[ix] = fill_state != 0; itg[ix] = fill_addr[31:9];
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    cyc++;
    case (rdy_mode)
      0: wb_ready = 1'b1;
      1: wb_ready = 1'b0;
      default: wb_ready = (cyc % 3 == 2);
    endcase
    if (rst_n && !done) begin
      chk("R8 busy", snp_busy, m_busy);
      chk("R1 hit", snp_hit, m_hit);
      chk("R5 hitm", snp_hitm, m_hitm);
      chk("R12 dstate", snp_dstate, m_dst);
      chk("R9 wb_valid", wb_valid, m_busy);
      if (m_busy) begin
        chk("R9 wb_addr", wb_addr, {m_tag[22:0], m_idx[3:0], 5'b0});
        chk("R9 wb_data", wb_data, dd[m_idx]);
      end
    end
  end

  function automatic logic [31:0] mk(input int tag, input int idx);
    return {tag[22:0], idx[3:0], 5'b0};
  endfunction

  task automatic fill(input bit dc, input logic [31:0] a, input logic [1:0] s, input logic [63:0] d);
    fill_en = 1; fill_dcache = dc; fill_addr = a; fill_state = s; fill_data = d;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic snoop(input logic [31:0] a, input bit inv);
    snp_valid = 1; snp_addr = a; snp_inv = inv;
    @(negedge clk);
    snp_valid = 0; snp_inv = ~inv; snp_addr = '0;   // later value must not matter (R7)
  endtask

  task automatic wait_idle;
    while (snp_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset busy", snp_busy, 0);
    chk("R1 reset hit", snp_hit, 0);
    chk("R9 reset wb_valid", wb_valid, 0);

    snoop(mk(7, 0), 0);
    chk("R10 empty miss hit", snp_hit, 0);
    chk("R10 empty miss hitm", snp_hitm, 0);

    fill(0, mk('h55, 1), 2'd1, '0);
    snoop(mk('h55, 1), 0);
    chk("R1 icache hit", snp_hit, 1);
    chk("R12 icache-only dstate", snp_dstate, 0);
    snoop(mk('h55, 1), 0);
    chk("R2 still valid", snp_hit, 1);
    snoop(mk('h55, 1), 1);
    chk("R3 hit before clear", snp_hit, 1);
    snoop(mk('h55, 1), 0);
    chk("R3 cleared", snp_hit, 0);

    fill(1, mk('h66, 2), 2'd2, 64'h1111);
    snoop(mk('h66, 2), 0);
    chk("R4 exclusive hit", snp_hit, 1);
    chk("R4 no hitm", snp_hitm, 0);
    chk("R12 exclusive seen", snp_dstate, 2);
    chk("R4 no writeback", wb_valid, 0);
    snoop(mk('h66, 2), 0);
    chk("R4 now shared", snp_dstate, 1);

    fill(1, mk('h77, 3), 2'd3, 64'hDEAD_BEEF_0BAD_F00D);
    rdy_mode = 1;
    @(negedge clk);
    snoop(mk('h77, 3), 0);
    chk("R5 hitm", snp_hitm, 1);
    chk("R8 busy", snp_busy, 1);
    chk("R5 wb addr", wb_addr, mk('h77, 3));
    chk("R5 wb data", wb_data, 64'hDEAD_BEEF_0BAD_F00D);
    snoop(mk('h66, 2), 1);            // ignored: busy
    fill(1, mk('h11, 6), 2'd2, '0);   // ignored: busy
    chk("R8 result held", snp_hitm, 1);
    chk("R9 still offered", wb_valid, 1);
    rdy_mode = 2;
    wait_idle;
    snoop(mk('h77, 3), 0);
    chk("R5 shared after wb", snp_dstate, 1);
    chk("R5 no hitm after wb", snp_hitm, 0);
    snoop(mk('h66, 2), 0);
    chk("R8 ignored strobe kept line", snp_dstate, 1);
    snoop(mk('h11, 6), 0);
    chk("R11 install while busy dropped", snp_hit, 0);

    fill(1, mk('h88, 4), 2'd3, 64'h4444_5555);
    snoop(mk('h88, 4), 1);
    chk("R6 modified hitm", snp_hitm, 1);
    wait_idle;
    snoop(mk('h88, 4), 0);
    chk("R6 invalid after wb", snp_hit, 0);
    chk("R7 inv held through wb", snp_dstate, 0);

    snoop(mk('h99, 2), 1);
    chk("R10 tag mismatch miss", snp_hit, 0);
    snoop(mk('h66, 2), 0);
    chk("R10 line untouched", snp_dstate, 1);

    fill(0, mk('hAA, 5), 2'd1, '0);
    fill(1, mk('hAA, 5), 2'd1, 64'h5);
    snoop(mk('hAA, 5), 1);
    chk("R1 both hit", snp_hit, 1);
    snoop(mk('hAA, 5), 0);
    chk("R6 both dropped", snp_hit, 0);

    fill_en = 1; fill_dcache = 1; fill_addr = mk('hBB, 7); fill_state = 2'd2; fill_data = '0;
    snoop(mk('h12, 9), 0);
    fill_en = 0;
    snoop(mk('hBB, 7), 0);
    chk("R11 install with strobe dropped", snp_hit, 0);

    rdy_mode = 0;
    repeat (2) @(negedge clk);
    summary;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary;
  end
endmodule